// File: doc/BRIEF.md
# Dual Lock Status Qualifier

This block merges two raw phase-lock indications into a single lock status flag. One indication comes from the transmit clock synthesizer and the other from the receive clock recovery. The block runs on the 125 MHz reference clock. Before the flag reports lock, both indications must stay true for a long unbroken window. Once the flag reports lock, it only drops after one of the indications has stayed false for an even longer unbroken window. The asymmetry gives hysteresis, so a lock indication that chatters does not make the shared status line toggle.

A reset request pin is filtered, and only a low level that lasts several reference cycles is accepted. An accepted reset clears the flag, restarts every qualification, and keeps the flag low for a minimum time after the pin is released. The output is a pull-down enable for an open-drain net with a pull-up, so several instances can share one status line. A separate enable input, when low, releases the pull-down so the line reads high whatever the internal state is. All window lengths are parameters. The defaults (49 250, 131 625 and 49 250 cycles) match the real-time figures at 125 MHz, and shorter values can be used in simulation.

Top module: `lockq_status`

## Requirements
- R1: With out_en high and the hold window over, `lock_pd_n` rises on the (ASSERT_CYC+2)-th rising clock edge after both raw lock inputs go high and stay high. It is still low on the edge before that. The two extra edges are the synchronizer stages.
- R2: Once locked, `lock_pd_n` falls on the (DROP_CYC+2)-th rising edge after either raw lock input (or both) goes low and stays low. It is still high on the edge before that.
- R3: A break in either qualifying condition restarts that window from zero. A one-input dropout of a few cycles during assertion qualification, or a brief return of both inputs during drop qualification, delays the output change by a full window counted from the end of the break.
- R4: Holding `rst_pin_n` low for RST_MIN_CYC or more consecutive edges drives `lock_pd_n` low on the (RST_MIN_CYC+3)-th edge after the pin falls. It stays low while the pin stays low.
- R5: A low pulse on `rst_pin_n` shorter than RST_MIN_CYC edges has no effect on `lock_pd_n`.
- R6: After an accepted reset, `lock_pd_n` stays low for HOLD_CYC cycles. With both lock inputs high throughout and HOLD_CYC >= ASSERT_CYC, it rises on the (HOLD_CYC+4)-th edge after `rst_pin_n` returns high. It is still low on the edge before that.
- R7: While `out_en` is 0, `lock_pd_n` reads 1 in the same cycle. Raising `out_en` back to 1 shows the internal state again, and qualification carries on unaffected by the override.
- R8: While `por_n` is low, `lock_pd_n` is 0 (with `out_en` high). The hold window of R6 also runs from the release of `por_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 125 MHz reference clock |
| por_n | input | 1 | Asynchronous power-on reset of the clock domain, active low |
| rst_pin_n | input | 1 | Reset request, active low. It is asynchronous and filtered by minimum width |
| tx_lock_raw | input | 1 | Raw transmit-side lock indication, asynchronous |
| rx_lock_raw | input | 1 | Raw receive-side lock indication, asynchronous |
| out_en | input | 1 | Output enable. Low releases the pull-down so the line reads 1 |
| lock_pd_n | output | 1 | Pull-down control for the shared lock line. 0 pulls the line low (no lock), 1 releases it (locked or disabled) |

## Verification
The assertions rely on `por_n` having been pulsed before any other activity. They also rely on the raw lock and reset inputs being level signals that each settle well inside one clock period, so each sampled change reaches the counters as a single clean step through the synchronizer. `out_en` is treated as a slow strap that changes only between clock edges. The bench respects all of this by changing every input on the falling clock edge and never toggling an input twice within one cycle. It also chooses HOLD_CYC above ASSERT_CYC, so the post-reset hold and the assertion window give distinct release times that can be told apart.

// File: rtl/lockq_pkg.sv
package lockq_pkg;

  // Selects which event a run counter reports.
  typedef enum logic {
    HIT_FULL, // counter has reached its limit
    HIT_LAST  // the current cycle completes the run
  } hit_mode_e;

  // Width needed to hold values 0..lim.
  function automatic int unsigned cnt_bits(int unsigned lim);
    if (lim < 1) return 1;
    return $clog2(lim + 1);
  endfunction

  // One step of a saturating run-length counter: cleared when the
  // condition is false, incremented up to lim while it is true.
  function automatic int unsigned run_step(int unsigned cur, logic cond,
                                           int unsigned lim);
    if (!cond) return 0;
    return (cur < lim) ? cur + 1 : cur;
  endfunction

endpackage

// File: rtl/lockq_sync.sv
module lockq_sync #(
  parameter int unsigned        WIDTH   = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lockq_run_ctr.sv
module lockq_run_ctr
  import lockq_pkg::*;
#(
  parameter int unsigned LIMIT = 4,
  parameter hit_mode_e   MODE  = HIT_FULL
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);

  localparam int unsigned   CW    = cnt_bits(LIMIT);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);
  localparam logic [CW-1:0] PRE_C = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = CW'(run_step(32'(cnt_q), inc, LIMIT));
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  generate
    if (MODE == HIT_FULL) begin : g_full
      assign hit = (cnt_q == LIM_C);
    end else begin : g_last
      assign hit = inc && !clr && (cnt_q >= PRE_C);
    end
  endgenerate

endmodule

// File: rtl/lockq_status.sv
module lockq_status
  import lockq_pkg::*;
#(
  parameter int unsigned ASSERT_CYC  = 49250,
  parameter int unsigned DROP_CYC    = 131625,
  parameter int unsigned HOLD_CYC    = 49250,
  parameter int unsigned RST_MIN_CYC = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic tx_lock_raw,
  input  logic rx_lock_raw,
  input  logic out_en,
  output logic lock_pd_n
);

  localparam int unsigned SYNC_W = 3;

  // Synchronized inputs: bit 2 reset pin, bit 1 receive lock, bit 0 transmit lock.
  logic [SYNC_W-1:0] sync_q;
  logic              tx_lock_s;
  logic              rx_lock_s;
  logic              rst_sync_n;

  // Named internal events, observed by the bound checker.
  logic both_ok_s;
  logic rst_active;
  logic qual_up;
  logic qual_dn;
  logic hold_done;
  logic lock_q;

  lockq_sync #(
    .WIDTH   (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk    (clk_ref),
    .arst_n (por_n),
    .d      ({rst_pin_n, rx_lock_raw, tx_lock_raw}),
    .q      (sync_q)
  );

  assign tx_lock_s  = sync_q[0];
  assign rx_lock_s  = sync_q[1];
  assign rst_sync_n = sync_q[2];
  assign both_ok_s  = tx_lock_s & rx_lock_s;

  // Reset request is accepted once it has been low long enough.
  lockq_run_ctr #(.LIMIT(RST_MIN_CYC), .MODE(HIT_FULL)) u_rst_filt (
    .clk    (clk_ref),
    .arst_n (por_n),
    .clr    (1'b0),
    .inc    (!rst_sync_n),
    .hit    (rst_active)
  );

  // Unbroken run of both indications high.
  lockq_run_ctr #(.LIMIT(ASSERT_CYC), .MODE(HIT_LAST)) u_up_ctr (
    .clk    (clk_ref),
    .arst_n (por_n),
    .clr    (rst_active),
    .inc    (both_ok_s),
    .hit    (qual_up)
  );

  // Unbroken run of at least one indication low.
  lockq_run_ctr #(.LIMIT(DROP_CYC), .MODE(HIT_LAST)) u_dn_ctr (
    .clk    (clk_ref),
    .arst_n (por_n),
    .clr    (rst_active),
    .inc    (!both_ok_s),
    .hit    (qual_dn)
  );

  // Minimum low time after an accepted reset or power-on.
  lockq_run_ctr #(.LIMIT(HOLD_CYC), .MODE(HIT_FULL)) u_hold_ctr (
    .clk    (clk_ref),
    .arst_n (por_n),
    .clr    (rst_active),
    .inc    (1'b1),
    .hit    (hold_done)
  );

  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n)                              lock_q <= 1'b0;
    else if (rst_active)                     lock_q <= 1'b0;
    else if (!lock_q && qual_up && hold_done) lock_q <= 1'b1;
    else if (lock_q && qual_dn)              lock_q <= 1'b0;
  end

  // Pull-down released when locked, or when the output is disabled.
  assign lock_pd_n = lock_q | ~out_en;

endmodule

// File: rtl/lockq_status_chk.sv
module lockq_status_chk
  import lockq_pkg::*;
#(
  parameter int unsigned ASSERT_CYC  = 49250,
  parameter int unsigned DROP_CYC    = 131625,
  parameter int unsigned HOLD_CYC    = 49250,
  parameter int unsigned RST_MIN_CYC = 4
) (
  input logic clk_ref,
  input logic por_n,
  input logic out_en,
  input logic lock_pd_n,
  input logic lock_q,
  input logic both_ok_s,
  input logic rst_sync_n,
  input logic rst_active
);

  localparam int unsigned   OW     = cnt_bits(ASSERT_CYC);
  localparam int unsigned   BW     = cnt_bits(DROP_CYC);
  localparam int unsigned   RW     = cnt_bits(RST_MIN_CYC);
  localparam int unsigned   HW     = cnt_bits(HOLD_CYC + 1);
  localparam logic [OW-1:0] OK_LIM = OW'(ASSERT_CYC);
  localparam logic [BW-1:0] BD_LIM = BW'(DROP_CYC);
  localparam logic [RW-1:0] RM_LIM = RW'(RST_MIN_CYC);
  localparam logic [HW-1:0] HD_LIM = HW'(HOLD_CYC);

  // Independent run-length counters kept by the checker.
  logic [OW-1:0] ok_run_q;
  logic [BW-1:0] bad_run_q;
  logic [RW-1:0] rst_low_q;
  logic [HW-1:0] since_rst_q;

  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n) begin
      ok_run_q    <= '0;
      bad_run_q   <= '0;
      rst_low_q   <= '0;
      since_rst_q <= '0;
    end else begin
      ok_run_q    <= OW'(run_step(32'(ok_run_q), both_ok_s, ASSERT_CYC));
      bad_run_q   <= BW'(run_step(32'(bad_run_q), !both_ok_s, DROP_CYC));
      rst_low_q   <= RW'(run_step(32'(rst_low_q), !rst_sync_n, RST_MIN_CYC));
      since_rst_q <= rst_active ? '0
                                : HW'(run_step(32'(since_rst_q), 1'b1, HOLD_CYC + 1));
    end
  end

  assert_rise_qualified_R1: assert property (@(posedge clk_ref) disable iff (!por_n)
    $rose(lock_q) |-> (ok_run_q >= OK_LIM));

  assert_drop_qualified_R2: assert property (@(posedge clk_ref) disable iff (!por_n)
    $fell(lock_q) |-> ((bad_run_q >= BD_LIM) || $past(rst_active)));

  assert_reset_forces_low_R4: assert property (@(posedge clk_ref) disable iff (!por_n)
    rst_active |=> !lock_q);

  assert_short_pulse_ignored_R5: assert property (@(posedge clk_ref) disable iff (!por_n)
    rst_active |-> (rst_low_q >= RM_LIM));

  assert_hold_after_reset_R6: assert property (@(posedge clk_ref) disable iff (!por_n)
    $rose(lock_q) |-> (since_rst_q > HD_LIM));

  assert_disable_reads_high_R7: assert property (@(posedge clk_ref) disable iff (!por_n)
    !out_en |-> lock_pd_n);

endmodule

bind lockq_status lockq_status_chk #(
  .ASSERT_CYC  (ASSERT_CYC),
  .DROP_CYC    (DROP_CYC),
  .HOLD_CYC    (HOLD_CYC),
  .RST_MIN_CYC (RST_MIN_CYC)
) u_chk (
  .clk_ref    (clk_ref),
  .por_n      (por_n),
  .out_en     (out_en),
  .lock_pd_n  (lock_pd_n),
  .lock_q     (lock_q),
  .both_ok_s  (both_ok_s),
  .rst_sync_n (rst_sync_n),
  .rst_active (rst_active)
);

// File: tb/lockq_status_bench.sv
module lockq_status_bench;

  localparam int unsigned A_C = 20;
  localparam int unsigned D_C = 50;
  localparam int unsigned H_C = 30;
  localparam int unsigned R_C = 4;

  logic clk = 1'b0;
  logic por_n;
  logic rst_pin_n;
  logic tx_lock_raw;
  logic rx_lock_raw;
  logic out_en;
  logic lock_pd_n;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lockq_status #(
    .ASSERT_CYC  (A_C),
    .DROP_CYC    (D_C),
    .HOLD_CYC    (H_C),
    .RST_MIN_CYC (R_C),
    .SYNC_STAGES (2)
  ) u_lockq_status (
    .clk_ref     (clk),
    .por_n       (por_n),
    .rst_pin_n   (rst_pin_n),
    .tx_lock_raw (tx_lock_raw),
    .rx_lock_raw (rx_lock_raw),
    .out_en      (out_en),
    .lock_pd_n   (lock_pd_n)
  );

  typedef struct packed {
    logic       tx;
    logic       rx;
    logic       en;
    logic [7:0] edges;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  // Edge counts come from the requirements: rise on edge A+2, fall on edge D+2.
  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 8'(A_C + 1), 1'b0, 4'd1}, // R1 one edge early
    '{1'b1, 1'b1, 1'b1, 8'd1,        1'b1, 4'd1}, // R1 rises
    '{1'b0, 1'b1, 1'b1, 8'(D_C + 1), 1'b1, 4'd2}, // R2 one edge early
    '{1'b0, 1'b1, 1'b1, 8'd1,        1'b0, 4'd2}, // R2 falls
    '{1'b1, 1'b1, 1'b1, 8'd10,       1'b0, 4'd3}, // R3 partial run
    '{1'b1, 1'b0, 1'b1, 8'd3,        1'b0, 4'd3}, // R3 dropout
    '{1'b1, 1'b1, 1'b1, 8'(A_C + 1), 1'b0, 4'd3}, // R3 restarted run
    '{1'b1, 1'b1, 1'b1, 8'd1,        1'b1, 4'd3}, // R3 rises
    '{1'b1, 1'b0, 1'b1, 8'd30,       1'b1, 4'd3}, // R3 partial drop
    '{1'b1, 1'b1, 1'b1, 8'd2,        1'b1, 4'd3}, // R3 brief recovery
    '{1'b1, 1'b0, 1'b1, 8'(D_C + 1), 1'b1, 4'd3}, // R3 restarted drop
    '{1'b1, 1'b0, 1'b1, 8'd1,        1'b0, 4'd3}, // R3 falls
    '{1'b0, 1'b0, 1'b0, 8'd0,        1'b1, 4'd7}, // R7 disabled reads 1
    '{1'b0, 1'b0, 1'b1, 8'd0,        1'b0, 4'd7}, // R7 enabled shows state
    '{1'b1, 1'b1, 1'b1, 8'(A_C + 2), 1'b1, 4'd1}, // R1 lock again
    '{1'b0, 1'b0, 1'b1, 8'(D_C + 1), 1'b1, 4'd2}, // R2 both low, early
    '{1'b0, 1'b0, 1'b1, 8'd1,        1'b0, 4'd2}, // R2 both low falls
    '{1'b1, 1'b1, 1'b0, 8'd5,        1'b1, 4'd7}, // R7 override during qualification
    '{1'b1, 1'b1, 1'b1, 8'd0,        1'b0, 4'd7}, // R7 state visible again
    '{1'b1, 1'b1, 1'b1, 8'(A_C - 4), 1'b0, 4'd7}, // R7 qualification unaffected
    '{1'b1, 1'b1, 1'b1, 8'd1,        1'b1, 4'd1}  // R1 rises on schedule
  };

  task automatic edges(input int n);
    if (n == 0) #1;
    else begin
      repeat (n) @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input logic exp, input string tag);
    n_vec++;
    if (lock_pd_n !== exp) begin
      n_bad++;
      $display("FAIL %s: lock_pd_n=%0b expected %0b at %0t", tag, lock_pd_n, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run still active=1 expected 0");
    finish_run();
  end

  initial begin
    por_n = 1'b0; rst_pin_n = 1'b1; tx_lock_raw = 1'b0; rx_lock_raw = 1'b0; out_en = 1'b1;
    edges(3);
    check(1'b0, "R8 power-on state");
    @(negedge clk);
    por_n = 1'b1;
    rst_pin_n = 1'b0;
    edges(8);
    rst_pin_n = 1'b1;
    edges(H_C + 10);
    check(1'b0, "R8 idle after reset");

    for (int i = 0; i < NV; i++) begin
      tx_lock_raw = VECS[i].tx;
      rx_lock_raw = VECS[i].rx;
      out_en      = VECS[i].en;
      edges(int'(VECS[i].edges));
      check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // Locked, both inputs high from here on.
    edges(5);
    check(1'b1, "R1 still locked");

    // R5: pulse one edge short of the minimum.
    rst_pin_n = 1'b0;
    edges(int'(R_C) - 1);
    rst_pin_n = 1'b1;
    edges(12);
    check(1'b1, "R5 short reset ignored");

    // R4: minimum-length pulse, output falls on edge R_C+3.
    rst_pin_n = 1'b0;
    edges(int'(R_C));
    rst_pin_n = 1'b1;
    edges(2);
    check(1'b1, "R4 before forced low");
    edges(1);
    check(1'b0, "R4 forced low");
    // R6: rise on edge H_C+4 after the release.
    edges(int'(H_C));
    check(1'b0, "R6 hold one edge early");
    edges(1);
    check(1'b1, "R6 rises after hold");

    // R4 / R7: long reset, override during reset.
    rst_pin_n = 1'b0;
    edges(10);
    check(1'b0, "R4 held low during reset");
    out_en = 1'b0;
    edges(0);
    check(1'b1, "R7 override during reset");
    out_en = 1'b1;
    edges(0);
    check(1'b0, "R7 override removed");
    rst_pin_n = 1'b1;
    edges(int'(H_C) + 8);
    check(1'b1, "R6 relock after long reset");

    finish_run();
  end

endmodule